// File: doc/BRIEF.md
# Alert response responder

This block is the device-side half of the SMBus alert mechanism. When the local fault logic raises a request, the block pulls the shared open-drain alert line low. It then watches the serial bus for the master's read of the Alert Response Address. When that read arrives, the block acknowledges it and returns its own 7-bit address, followed by a 1, in the data byte.

Several devices may answer the same read at once. Each responder compares the line with the bit it is sending, and the device with the lowest address wins through wired-AND arbitration. The winner releases its alert line and pulses a serviced output to the fault logic. A loser keeps its alert line low and waits for a later round. An ordinary addressing of the device, reported by the address decoder as a one-cycle pulse, also releases the alert line.

SCL and SDA arrive as synchronous samples. The block drives SDA only through a pull-low enable.

Top module: `alert_responder`

## Requirements
- R1: A one-cycle `alert_req_i` sets the pending alert, and `alert_pull_o` is high from the next clock until the alert is serviced or the device is addressed.
- R2: START is SDA going 1 to 0 and STOP is SDA going 0 to 1, each over two consecutive samples with SCL high in both. Bus activity that does not follow a START gets no response.
- R3: After a START, the block shifts in 8 bits on SCL rising edges, MSB first. The byte is 0x19: address 0001100 followed by read bit 1. If that byte arrives while an alert is pending, the block pulls SDA low from the SCL falling edge after the eighth bit to the next falling edge. It does not acknowledge any other byte, or this byte when no alert is pending.
- R4: The data byte is `dev_addr_i` MSB first, followed by a final 1. `sda_pull_o` is the inverse of the current bit. It changes one clock after the SCL falling edge that starts the bit, and it never rises while SCL is sampled high.
- R5: On each SCL rising edge of the data byte, the block compares the line with its own bit. Reading 0 while sending 1 loses arbitration: `sda_pull_o` stays low for the rest of the byte, no serviced pulse follows, and `alert_pull_o` stays high.
- R6: When the eighth data bit completes without a loss, `serviced_o` is high for exactly one clock, starting the clock after that bit's SCL rising edge. `alert_pull_o` drops in the same clock.
- R7: A one-cycle `dev_hit_i` clears the pending alert, and `alert_pull_o` is low from the next clock.
- R8: A STOP or a repeated START during a response ends it. `sda_pull_o` is low from the next clock and the alert stays pending.
- R9: When `alert_req_i` and a clearing event (`dev_hit_i` or a win) occur in the same clock, the alert stays pending.
- R10: During and right after reset, `sda_pull_o`, `alert_pull_o` and `serviced_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line (wired-AND of all drivers) |
| sda_pull_o | output | 1 | SDA pull-low enable |
| alert_req_i | input | 1 | Pulse: new alert from the fault controller |
| dev_addr_i | input | AW | Configured 7-bit device address |
| dev_hit_i | input | 1 | Pulse: device addressed in a normal transaction |
| alert_pull_o | output | 1 | Alert line pull-low enable |
| serviced_o | output | 1 | Pulse: alert response won and completed |

## Verification
A wrong phase or bit counter shows on `sda_pull_o` at the SCL falling edge where the acknowledge or a data bit should begin, one clock after that edge. A wrong arbitration decision shows on `sda_pull_o` at the next falling edge. It also shows as a serviced pulse that should not occur, or one that is missing, together with an alert line that drops or stays low when it should not. A wrong pending flag shows on `alert_pull_o` in the clock after a request, a hit or a win. The reference model runs in step with the design, so every such fault is caught in the clock where it first reaches a port.

// File: rtl/alert_responder.sv
module alert_responder #(
  parameter int AW = 7,
  parameter logic [AW-1:0] ARA = AW'(7'h0C)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_pull_o,
  input  logic          alert_req_i,
  input  logic [AW-1:0] dev_addr_i,
  input  logic          dev_hit_i,
  output logic          alert_pull_o,
  output logic          serviced_o
);
  localparam int BW = AW + 1;
  localparam int CW = $clog2(BW);
  localparam logic [CW-1:0] LAST = CW'(BW - 1);

  typedef enum logic [1:0] {IDLE, ADDR, ACK, SEND} st_t;

  st_t           st;
  logic          scl_q, sda_q, drv, pend, srv;
  logic [CW-1:0] cnt;
  logic [BW-1:0] sh;

  wire rise  = scl_i & ~scl_q;
  wire fall  = ~scl_i & scl_q;
  wire start = scl_i & scl_q & sda_q & ~sda_i;
  wire stop  = scl_i & scl_q & ~sda_q & sda_i;
  wire [BW-1:0] tx = {dev_addr_i, 1'b1};
  wire match = ({sh[BW-2:0], sda_i} == {ARA, 1'b1});
  wire lost  = sh[BW-1] & ~sda_i;
  wire win   = (st == SEND) & rise & ~start & ~stop & ~lost & (cnt == LAST);

  assign sda_pull_o   = drv;
  assign alert_pull_o = pend;
  assign serviced_o   = srv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      st    <= IDLE;
      cnt   <= '0;
      sh    <= '0;
      drv   <= 1'b0;
      pend  <= 1'b0;
      srv   <= 1'b0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      srv   <= win;
      if (alert_req_i)          pend <= 1'b1;
      else if (win | dev_hit_i) pend <= 1'b0;
      if (start) begin
        st  <= ADDR;
        cnt <= '0;
        drv <= 1'b0;
      end else if (stop) begin
        st  <= IDLE;
        drv <= 1'b0;
      end else begin
        case (st)
          ADDR: if (rise) begin
            sh  <= {sh[BW-2:0], sda_i};
            cnt <= cnt + 1'b1;
            if (cnt == LAST) st <= (match && pend) ? ACK : IDLE;
          end
          ACK: if (fall) begin
            if (!drv) drv <= 1'b1;
            else begin
              st  <= SEND;
              cnt <= '0;
              sh  <= tx;
              drv <= ~tx[BW-1];
            end
          end
          SEND: begin
            if (rise) begin
              if (lost) begin
                st  <= IDLE;
                drv <= 1'b0;
              end else if (cnt == LAST) begin
                st <= IDLE;
              end else begin
                cnt <= cnt + 1'b1;
                sh  <= sh << 1;
              end
            end else if (fall) begin
              drv <= ~sh[BW-1];
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_REQ_RAISES_ALERT: assert property (@(posedge clk) disable iff (!rst_n) alert_req_i |=> alert_pull_o); // R1
  AST_HIT_DROPS_ALERT: assert property (@(posedge clk) disable iff (!rst_n) dev_hit_i && !alert_req_i |=> !alert_pull_o); // R7
  AST_PULL_RISES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(sda_pull_o) |-> !scl_q); // R4
  AST_SRV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) serviced_o |=> !serviced_o); // R6
  AST_SRV_LAST_BIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n) serviced_o |-> $past(sda_i) && $past(scl_i)); // R6
  AST_SRV_RELEASES: assert property (@(posedge clk) disable iff (!rst_n) serviced_o && !$past(alert_req_i) |-> !alert_pull_o); // R6
  AST_BUS_EVENT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n) (start || stop) |=> !sda_pull_o); // R8
endmodule

// File: tb/sim_alert_responder.sv
module sim_alert_responder;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, msda = 1'b1, rsda = 1'b1;
  logic req = 1'b0, hit = 1'b0;
  logic [6:0] addr = 7'h52;
  logic sda_pull, alert_pull, serviced;
  logic sda_line;
  assign sda_line = msda & rsda & ~sda_pull;

  int n_cmp = 0, n_bad = 0, srv_cnt = 0, cycles = 0;
  logic pull_seen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alert_responder u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .alert_req_i(req), .dev_addr_i(addr),
    .dev_hit_i(hit), .alert_pull_o(alert_pull), .serviced_o(serviced));

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req_tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", req_tag, $time, act, exp);
    end
  endtask

  // Reference model
  int m_mode;
  bit m_pend, pscl, psda, exp_pull, exp_srv;
  bit q[$];
  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_pend = 0; pscl = 1; psda = 1; exp_pull = 0; exp_srv = 0;
      q.delete();
    end else begin
      bit c, l, won;
      int v;
      c = scl; l = sda_line; won = 0;
      if (c && pscl && psda && !l) begin
        m_mode = 1; q.delete(); exp_pull = 0;
      end else if (c && pscl && !psda && l) begin
        m_mode = 0; exp_pull = 0;
      end else if (m_mode == 1 && c && !pscl) begin
        q.push_back(l);
        if (q.size() == 8) begin
          v = 0;
          foreach (q[i]) v = v * 2 + int'(q[i]);
          m_mode = (m_pend && v == 8'h19) ? 2 : 0;
        end
      end else if (m_mode == 2 && !c && pscl) begin
        if (!exp_pull) exp_pull = 1;
        else begin
          q.delete();
          for (int i = 6; i >= 0; i--) q.push_back(addr[i]);
          q.push_back(1'b1);
          m_mode = 3; exp_pull = !q[0];
        end
      end else if (m_mode == 3 && c && !pscl) begin
        if (q[0] && !l) begin
          m_mode = 0; exp_pull = 0;
        end else begin
          void'(q.pop_front());
          if (q.size() == 0) begin won = 1; m_mode = 0; end
        end
      end else if (m_mode == 3 && !c && pscl) begin
        exp_pull = !q[0];
      end
      exp_srv = won;
      if (req) m_pend = 1;
      else if (won || hit) m_pend = 0;
      pscl = c; psda = l;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk({7'd0, sda_pull}, {7'd0, exp_pull}, "R4 sda_pull_o");
      chk({7'd0, alert_pull}, {7'd0, m_pend}, "R1 alert_pull_o");
      chk({7'd0, serviced}, {7'd0, exp_srv}, "R6 serviced_o");
      if (serviced) srv_cnt++;
      if (sda_pull) pull_seen = 1'b1;
    end
  end

  task automatic hp(); repeat (HALF) @(negedge clk); endtask
  task automatic xbit(input logic b, input logic rb, output logic rd);
    msda = b; rsda = rb; hp(); scl = 1'b1; hp(); rd = sda_line; scl = 1'b0; hp();
  endtask
  task automatic bus_start(); msda = 1'b1; hp(); scl = 1'b1; hp(); msda = 1'b0; hp(); scl = 1'b0; hp(); endtask
  task automatic bus_stop(); msda = 1'b0; hp(); scl = 1'b1; hp(); msda = 1'b1; hp(); endtask
  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) xbit(b[i], 1'b1, r);
    xbit(1'b1, 1'b1, ack);
  endtask
  task automatic rd_byte(input logic [7:0] rival, output logic [7:0] got);
    logic r, rl, rb;
    rl = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      rb = rl ? 1'b1 : rival[i];
      xbit(1'b1, rb, r);
      if (rb && !r) rl = 1'b1;
      got[i] = r;
    end
    rsda = 1'b1;
  endtask
  task automatic pulse_req(); req = 1'b1; @(negedge clk); req = 1'b0; endtask
  task automatic pulse_hit(); hit = 1'b1; @(negedge clk); hit = 1'b0; endtask
  task automatic ara_round(input logic [7:0] rival, output logic ack, output logic [7:0] got);
    logic r;
    bus_start(); wr_byte(8'h19, ack); rd_byte(rival, got); xbit(1'b1, 1'b1, r); bus_stop();
  endtask

  initial begin
    logic ack, r;
    logic [7:0] got;
    int s0;
    repeat (3) @(negedge clk);
    chk({5'd0, sda_pull, alert_pull, serviced}, 8'd0, "R10 reset outputs");
    rst_n = 1'b1; @(negedge clk);
    chk({5'd0, sda_pull, alert_pull, serviced}, 8'd0, "R10 after reset");

    // R3: ARA without pending alert gets no acknowledge
    pull_seen = 1'b0;
    ara_round(8'hFF, ack, got);
    chk({7'd0, ack}, 8'd1, "R3 no ack without alert");
    chk({7'd0, pull_seen}, 8'd0, "R3 no drive without alert");

    // R1: request raises alert
    pulse_req();
    chk({7'd0, alert_pull}, 8'd1, "R1 alert after request");

    // R2: ARA bits without START are ignored
    pull_seen = 1'b0;
    scl = 1'b0; hp();
    for (int i = 7; i >= 0; i--) xbit(r8(8'h19, i), 1'b1, r);
    xbit(1'b1, 1'b1, ack);
    scl = 1'b1; hp();
    chk({7'd0, pull_seen}, 8'd0, "R2 no response without START");

    // R3: a write to the ARA is not acknowledged
    bus_start(); wr_byte(8'h18, ack); bus_stop();
    chk({7'd0, ack}, 8'd1, "R3 ARA write not acked");

    // R8: STOP during the data byte aborts the response (addr 0x52, bit 2 is a 1)
    s0 = srv_cnt;
    bus_start(); wr_byte(8'h19, ack);
    chk({7'd0, ack}, 8'd0, "R3 ack of ARA read");
    xbit(1'b1, 1'b1, r); xbit(1'b1, 1'b1, r);
    bus_stop(); @(negedge clk);
    chk({6'd0, sda_pull, alert_pull}, 8'd1, "R8 stop abort keeps alert");
    chk(8'(srv_cnt - s0), 8'd0, "R8 no serviced after stop");

    // R8: repeated START aborts, then a non-ARA address leaves alert pending
    bus_start(); wr_byte(8'h19, ack);
    xbit(1'b1, 1'b1, r); xbit(1'b1, 1'b1, r);
    bus_start(); wr_byte(8'hA4, ack); bus_stop();
    chk({6'd0, sda_pull, alert_pull}, 8'd1, "R8 repeated start abort");
    chk(8'(srv_cnt - s0), 8'd0, "R8 no serviced after restart");

    // R5: rival 0x50 beats 0x52 at the sixth bit
    ara_round({7'h50, 1'b1}, ack, got);
    chk(got, {7'h50, 1'b1}, "R5 rival address on bus");
    chk({7'd0, alert_pull}, 8'd1, "R5 loser keeps alert");
    chk(8'(srv_cnt - s0), 8'd0, "R5 no serviced on loss");

    // R4/R6: no rival, own address returned, alert released
    ara_round(8'hFF, ack, got);
    chk(got, {7'h52, 1'b1}, "R4 own address returned");
    chk({7'd0, alert_pull}, 8'd0, "R6 alert released on win");
    chk(8'(srv_cnt - s0), 8'd1, "R6 one serviced pulse");

    // R6: lower own address 0x31 beats rival 0x52
    addr = 7'h31; pulse_req();
    ara_round({7'h52, 1'b1}, ack, got);
    chk(got, {7'h31, 1'b1}, "R6 winner address on bus");
    chk({7'd0, alert_pull}, 8'd0, "R6 winner releases alert");
    chk(8'(srv_cnt - s0), 8'd2, "R6 second serviced pulse");

    // R7: normal addressing releases alert
    pulse_req(); pulse_hit();
    chk({7'd0, alert_pull}, 8'd0, "R7 hit releases alert");

    // R9: request wins over a clear in the same clock
    req = 1'b1; hit = 1'b1; @(negedge clk); req = 1'b0; hit = 1'b0;
    chk({7'd0, alert_pull}, 8'd1, "R9 set beats clear");

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  function automatic logic r8(input logic [7:0] v, input int i);
    return v[i];
  endfunction

  initial begin
    wait (cycles > 100000);
    n_cmp++; n_bad++;
    $display("FAIL R8 watchdog: ran %0d cycles, expected end before %0d", cycles, 100000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule